// File: doc/BRIEF.md
# eFuse Word Read Controller

This block gives software read access to a one-time-programmable fuse array through a small 32-bit register window. Software first powers the array up and enables automatic reads. It then places a word index in the main control register and captures it by toggling an address-capture bit high and then low. To launch the fetch, it toggles a launch bit high and then low. A busy flag appears in the control register straight away and stays up while the sequencer waits out a fixed access latency. When the flag drops, the fetched word is already in the data register.

The fuse contents are fixed when the block is built and are computed from a seed parameter. Byte `b` of the array holds `((b*29 + SEED) ^ (b >> 3)) mod 256`. A word is made of `WORD_BYTES` consecutive bytes, least significant byte first, and is zero-extended to 32 bits. The bits that would control fuse programming, and a second control register with one encryption-related bit, are only stored. They have no effect on the array.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset, offset 0x04 reads 0x0800_0000 (power-down bit 27 set, busy bit 26 clear), offset 0x08 reads 0 and offset 0x10 reads 0.
- R2: Writing the index field (bits 10:0 at offset 0x04) does not change the captured index. The index is captured only by a write that clears bit 11 while the stored bit 11 is 1, and the captured value is that write's bits 10:0.
- R3: A write to 0x04 that clears bit 25 while the stored bit 25 is 1 starts a read if that same write has bit 24 = 1 and bit 27 = 0. Busy (bit 26) reads 1 on the very next register read and stays 1 for exactly RD_LATENCY clock cycles.
- R4: The data register (0x08) changes only in the cycle that busy falls. It then holds the addressed word, made of the fuse bytes least significant first and zero-extended to 32 bits.
- R5: A launch toggle made while bit 27 = 1 or bit 24 = 0 is ignored: busy stays 0 and the data register keeps its value.
- R6: Address-capture and launch toggles made while busy is 1 are ignored. The read in flight completes with its own index, no second read follows, and that index stays captured.
- R7: A captured index at or beyond ARRAY_BYTES/WORD_BYTES returns a data value of 0.
- R8: At 0x04, bits 23:16, 14, 13 and 12 (write controls) and bits 27, 25, 24, 11 and 10:0 read back as written, and bits 31:28 and 15 read 0. At 0x10 only bit 10 reads back, and all other bits read 0.
- R9: Writes to offset 0x08 do not alter the data register.
- R10: Read data appears on the output one cycle after the read enable. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_re |

## Verification
The bench builds the block with WORD_BYTES = 2, RD_LATENCY = 5 and a non-default seed. This gives 256 words, which puts the valid/invalid index boundary at 255/256 inside the 11-bit index range, and shows zero extension of narrow words in the 32-bit data register. The short latency lets all four toggle writes of a sequence that tries to re-target the index and relaunch land inside one busy window. The exact busy length is counted with back-to-back reads of the control register.

// File: rtl/efuse_pkg.sv
package efuse_pkg;

  localparam logic [7:0] OFF_CTL1 = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h08;
  localparam logic [7:0] OFF_CTL4 = 8'h10;

  localparam int BIT_LATCH  = 11;
  localparam int BIT_RDEN   = 24;
  localparam int BIT_LAUNCH = 25;
  localparam int BIT_BUSY   = 26;
  localparam int BIT_PWRDN  = 27;
  localparam int BIT_CRYPT  = 10;

  localparam logic [31:0] CTL1_RW_MASK  = 32'h0BFF_7FFF;
  localparam logic [31:0] CTL1_RST_VAL  = 32'h0800_0000;
  localparam logic [31:0] CTL4_RW_MASK  = 32'h0000_0400;

  function automatic logic [7:0] fuse_byte(input int seed, input int idx);
    int v;
    v = (idx * 29 + seed) ^ (idx >> 3);
    return v[7:0];
  endfunction

endpackage

// File: rtl/efuse_array.sv
module efuse_array #(
  parameter int WORD_BYTES = 4,
  parameter int WORDS      = 128,
  parameter int SEED       = 8'h5A,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] q
);
  import efuse_pkg::*;

  logic [WORD_W-1:0] mem [WORDS];

  initial begin
    for (int w = 0; w < WORDS; w++) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        mem[w][8*b +: 8] = fuse_byte(SEED, w * WORD_BYTES + b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[idx];
  end

endmodule

// File: rtl/efuse_regs.sv
module efuse_regs #(
  parameter int ADDR_W  = 5,
  parameter int FADDR_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [31:0]        bus_rdata,
  input  logic               busy,
  input  logic [31:0]        data_word,
  output logic               latch_stb,
  output logic [FADDR_W-1:0] latch_addr,
  output logic               launch_stb,
  output logic               launch_ok
);
  import efuse_pkg::*;

  logic [31:0] ctl1_q;
  logic [31:0] ctl4_q;
  logic        hit_ctl1, hit_data, hit_ctl4;
  logic        wr_ctl1;

  assign hit_ctl1 = (bus_addr == ADDR_W'(OFF_CTL1));
  assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign hit_ctl4 = (bus_addr == ADDR_W'(OFF_CTL4));
  assign wr_ctl1  = bus_we && hit_ctl1;

  // Strobes are the high-then-low toggle: stored bit 1, new write 0.
  assign latch_stb  = wr_ctl1 && ctl1_q[BIT_LATCH] && !bus_wdata[BIT_LATCH];
  assign latch_addr = bus_wdata[FADDR_W-1:0];
  assign launch_stb = wr_ctl1 && ctl1_q[BIT_LAUNCH] && !bus_wdata[BIT_LAUNCH];
  assign launch_ok  = bus_wdata[BIT_RDEN] && !bus_wdata[BIT_PWRDN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q <= CTL1_RST_VAL;
      ctl4_q <= '0;
    end else if (bus_we) begin
      if (hit_ctl1) ctl1_q <= bus_wdata & CTL1_RW_MASK;
      if (hit_ctl4) ctl4_q <= bus_wdata & CTL4_RW_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (hit_ctl1)      bus_rdata <= ctl1_q | (32'(busy) << BIT_BUSY);
      else if (hit_data) bus_rdata <= data_word;
      else if (hit_ctl4) bus_rdata <= ctl4_q;
      else               bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/efuse_seq.sv
module efuse_seq #(
  parameter int WORD_BYTES = 4,
  parameter int WORDS      = 128,
  parameter int FADDR_W    = 11,
  parameter int RD_LATENCY = 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W     = $clog2(RD_LATENCY)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               latch_stb,
  input  logic [FADDR_W-1:0] latch_addr,
  input  logic               launch_stb,
  input  logic               launch_ok,
  input  logic [WORD_W-1:0]  rom_q,
  output logic               rom_en,
  output logic [IDX_W-1:0]   rom_idx,
  output logic               busy,
  output logic [31:0]        data_q,
  output logic [FADDR_W-1:0] addr_q
);
  logic [CNT_W-1:0] cnt;
  logic             out_of_range;

  assign out_of_range = (32'(addr_q) >= WORDS);
  assign rom_idx      = addr_q[IDX_W-1:0];
  assign rom_en       = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      data_q <= '0;
    end else if (!busy) begin
      if (latch_stb) addr_q <= latch_addr;
      if (launch_stb && launch_ok) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(RD_LATENCY - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy   <= 1'b0;
      data_q <= out_of_range ? 32'd0 : 32'(rom_q);
    end
  end

endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl #(
  parameter int ADDR_W      = 5,
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int RD_LATENCY  = 8,
  parameter int FUSE_SEED   = 8'h5A,
  localparam int FADDR_W    = 11,
  localparam int WORDS      = ARRAY_BYTES / WORD_BYTES,
  localparam int WORD_W     = WORD_BYTES * 8,
  localparam int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);
  logic               latch_stb, launch_stb, launch_ok;
  logic [FADDR_W-1:0] latch_addr;
  logic               rd_busy;
  logic [31:0]        rd_data;
  logic [FADDR_W-1:0] rd_addr;
  logic               rom_en;
  logic [IDX_W-1:0]   rom_idx;
  logic [WORD_W-1:0]  rom_q;

  efuse_regs #(.ADDR_W(ADDR_W), .FADDR_W(FADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .busy(rd_busy), .data_word(rd_data),
    .latch_stb(latch_stb), .latch_addr(latch_addr),
    .launch_stb(launch_stb), .launch_ok(launch_ok)
  );

  efuse_seq #(.WORD_BYTES(WORD_BYTES), .WORDS(WORDS), .FADDR_W(FADDR_W),
              .RD_LATENCY(RD_LATENCY)) u_seq (
    .clk(clk), .rst(rst),
    .latch_stb(latch_stb), .latch_addr(latch_addr),
    .launch_stb(launch_stb), .launch_ok(launch_ok),
    .rom_q(rom_q), .rom_en(rom_en), .rom_idx(rom_idx),
    .busy(rd_busy), .data_q(rd_data), .addr_q(rd_addr)
  );

  efuse_array #(.WORD_BYTES(WORD_BYTES), .WORDS(WORDS), .SEED(FUSE_SEED)) u_array (
    .clk(clk), .en(rom_en), .idx(rom_idx), .q(rom_q)
  );

endmodule

// File: rtl/efuse_rd_chk.sv
module efuse_rd_chk #(
  parameter int ADDR_W     = 5,
  parameter int FADDR_W    = 11,
  parameter int RD_LATENCY = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_we,
  input logic               busy,
  input logic [31:0]        data_q,
  input logic [FADDR_W-1:0] addr_q
);
  logic [31:0] run_len;
  logic        ctl1_wr;
  logic        launch_clear, gate_open;

  assign ctl1_wr      = bus_we && (bus_addr == ADDR_W'(8'h04));
  assign launch_clear = ((bus_wdata & 32'h0200_0000) == 32'd0);
  assign gate_open    = ((bus_wdata & 32'h0900_0000) == 32'h0100_0000);

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl1_wr && launch_clear));

  assert_busy_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(gate_open));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == RD_LATENCY));

  assert_data_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> $fell(busy));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));

endmodule

bind efuse_rd_ctrl efuse_rd_chk #(.ADDR_W(ADDR_W), .FADDR_W(FADDR_W),
                                  .RD_LATENCY(RD_LATENCY)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .busy(rd_busy), .data_q(rd_data), .addr_q(rd_addr)
);

// File: tb/tb_efuse_rd_ctrl.sv
module tb_efuse_rd_ctrl;
  localparam int AW    = 5;
  localparam int WB    = 2;
  localparam int LAT   = 5;
  localparam int SEED  = 8'hA7;
  localparam int BYTES = 512;
  localparam int WORDS = BYTES / WB;

  localparam logic [31:0] EN    = 32'h0100_0000;
  localparam logic [31:0] PD    = 32'h0800_0000;
  localparam logic [31:0] SET   = 32'h0000_0800;
  localparam logic [31:0] GO    = 32'h0200_0000;
  localparam logic [31:0] BUSYB = 32'h0400_0000;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we, bus_re;
  logic [31:0]   bus_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #4 clk = ~clk;

  efuse_rd_ctrl #(.ADDR_W(AW), .WORD_BYTES(WB), .ARRAY_BYTES(BYTES),
                  .RD_LATENCY(LAT), .FUSE_SEED(SEED)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r;
    int b, v;
    r = '0;
    if (w >= WORDS) return 32'd0;
    for (int k = 0; k < WB; k++) begin
      b = w * WB + k;
      v = (b * 29 + SEED) ^ (b >> 3);
      r[8*k +: 8] = v[7:0];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic latch_idx(input int idx);
    wr(8'h04, EN | 32'(idx[10:0]) | SET);
    wr(8'h04, EN | 32'(idx[10:0]));
  endtask

  task automatic launch();
    wr(8'h04, EN | GO);
    wr(8'h04, EN);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 50; i++) begin
      rd(8'h04, d);
      if ((d & BUSYB) == 0) return;
    end
    chk("R3 busy never cleared", d & BUSYB, 32'd0);
  endtask

  task automatic fetch(input int idx, input string req);
    logic [31:0] d;
    latch_idx(idx);
    launch();
    rd(8'h04, d);
    chk({req, " busy seen next read (R3)"}, d & BUSYB, BUSYB);
    wait_idle();
    rd(8'h08, d);
    chk(req, d, exp_word(idx));
  endtask

  initial begin
    logic [31:0] d, keep;
    int nb;
    void'($urandom(32'hC0FFEE));
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h04, d); chk("R1 ctl1 reset", d, 32'h0800_0000);
    rd(8'h08, d); chk("R1 data reset", d, 32'd0);
    rd(8'h10, d); chk("R1 ctl4 reset", d, 32'd0);

    // power up, enable auto-read
    wr(8'h04, EN);

    // R3 exact busy length with back-to-back reads
    latch_idx(1);
    launch();
    nb = 0;
    for (int i = 0; i < LAT + 3; i++) begin
      rd(8'h04, d);
      if ((d & BUSYB) != 0) nb++;
    end
    chk("R3 busy cycles", 32'(nb), 32'(LAT));
    rd(8'h08, d); chk("R4 word 1", d, exp_word(1));

    // R2 index field alone does not re-target
    latch_idx(3);
    wr(8'h04, EN | 32'd9);
    launch();
    wait_idle();
    rd(8'h08, d); chk("R2 field write ignored", d, exp_word(3));

    // R4/R7 boundaries
    fetch(0, "R4 word 0");
    fetch(WORDS - 1, "R4 last word");
    fetch(WORDS, "R7 first out-of-range");
    fetch(2047, "R7 max index");

    // R4/R7 random
    for (int i = 0; i < 40; i++) begin
      int a;
      a = (i % 5 == 4) ? int'($urandom_range(0, 2047)) : int'($urandom_range(0, WORDS + 20));
      fetch(a, "R4 random word");
    end

    // R5 gated launches
    fetch(7, "R4 word 7");
    rd(8'h08, keep);
    wr(8'h04, EN | PD | GO); wr(8'h04, EN | PD);
    rd(8'h04, d); chk("R5 power-down busy", d & BUSYB, 32'd0);
    wr(8'h04, GO); wr(8'h04, 32'd0);
    rd(8'h04, d); chk("R5 disabled busy", d & BUSYB, 32'd0);
    repeat (LAT + 2) @(negedge clk);
    rd(8'h08, d); chk("R5 data kept", d, keep);
    wr(8'h04, EN);

    // R6 toggles during busy
    latch_idx(5);
    launch();
    latch_idx(12);
    launch();
    wait_idle();
    rd(8'h08, d); chk("R6 in-flight index kept", d, exp_word(5));
    repeat (LAT + 2) @(negedge clk);
    rd(8'h04, d); chk("R6 no second read", d & BUSYB, 32'd0);
    launch();
    wait_idle();
    rd(8'h08, d); chk("R6 index still captured", d, exp_word(5));

    // R9 data register write
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'h08, d); chk("R9 data write ignored", d, exp_word(5));

    // R8 stored bits
    wr(8'h04, 32'hF0FF_F7FF);
    rd(8'h04, d); chk("R8 ctl1 readback", d, 32'h00FF_77FF);
    wr(8'h04, 32'h0BFF_F000);
    rd(8'h04, d); chk("R8 ctl1 upper bits", d, 32'h0BFF_7000);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R8 ctl4 readback", d, 32'h0000_0400);
    rd(8'h08, d); chk("R8 no programming effect", d, exp_word(5));

    // R10 unmapped offsets and one-cycle read
    rd(8'h00, d); chk("R10 offset 0x00", d, 32'd0);
    rd(8'h0C, d); chk("R10 offset 0x0C", d, 32'd0);
    rd(8'h14, d); chk("R10 offset 0x14", d, 32'd0);
    bus_re = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 idle rdata", bus_rdata, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule